// File: doc/BRIEF.md
# Pixel Link Frame Serializer

This block turns a parallel video pixel into a short serial frame on a two-lane link. Each pixel carries red, green and blue channels of eight bits and three timing bits: vertical sync, horizontal sync and data enable. All of them are taken in one cycle and then shifted out, two bits at a time. Every pixel becomes one self-contained link frame. The frame holds the color bits, the three timing bits, an odd-parity bit and a two-bit frame counter. The counter advances by one on every frame, so a receiver can lock onto the repeating count without any line coding.

The block runs on one fast clock at twice the link-clock rate. Each fast cycle is one phase of the link clock, so each lane sends one bit per phase, on both link-clock edges. The block drives the link clock it implies as `link_ck`. A one-cycle pixel strobe offers a new pixel. The block takes it only when it is idle or on the last slot of the frame in flight.

A mode input picks the frame size when the pixel is taken:
- **Narrow mode:** the upper six bits of each color are sent, giving 24 bits in 12 fast cycles.
- **Wide mode:** all eight bits of each color are sent, plus two reserved low bits, giving 32 bits in 16 fast cycles.

Top module: `pxl_link_serializer`

## Requirements
- R1: While `rst` is high and after it falls with no pixel taken, `lane_d` is 2'b00 and `link_ck` is 0. The first frame after reset carries sequence value 0.
- R2: With `wide_mode`=0 at acceptance, the frame is 24 bits long and lasts 12 cycles. Transmit bit order is r[7:2] MSB first, then g[7:2], then b[7:2], then vs, hs, de, the parity bit, seq[1] and seq[0].
- R3: With `wide_mode`=1 at acceptance, the frame is 32 bits long and lasts 16 cycles. Transmit bit order is r[7:0], g[7:0] and b[7:0], each MSB first, then vs, hs, de, parity, seq[1], seq[0], and two reserved bits that are 0.
- R4: The parity bit makes the count of ones odd. The count covers every color bit sent, vs, hs, de, seq[1], seq[0] and the parity bit itself.
- R5: The two-bit sequence field rises by one on each accepted pixel and wraps from 3 to 0.
- R6: Transmit bit 2k appears on `lane_d[0]` and bit 2k+1 on `lane_d[1]` during slot k. Slot 0 is the cycle right after the clock edge that accepts the pixel, and each later slot follows one cycle after the one before it.
- R7: A pixel is accepted on a rising edge where `pix_stb` is 1 and the block is idle or in the last slot of its frame. A strobe on any other cycle is ignored, and the frame in flight runs on unchanged.
- R8: Pixel fields and `wide_mode` are captured at acceptance. Changes to them during a frame do not alter that frame.
- R9: When a frame ends with no new pixel accepted, `lane_d` is 2'b00 and `link_ck` is 0 until the next acceptance.
- R10: During a frame, `link_ck` is 1 in even slots and 0 in odd slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the link-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | Offers a new pixel this cycle |
| wide_mode | input | 1 | 1 = 32-bit frame, 0 = 24-bit frame |
| pix_r | input | 8 | Red channel |
| pix_g | input | 8 | Green channel |
| pix_b | input | 8 | Blue channel |
| pix_vs | input | 1 | Vertical sync, passed through as is |
| pix_hs | input | 1 | Horizontal sync, passed through as is |
| pix_de | input | 1 | Data enable, passed through as is |
| lane_d | output | 2 | Serial lanes: bit 0 even payload bits, bit 1 odd payload bits |
| link_ck | output | 1 | Link clock, one phase per fast cycle |

## Verification
The assertions do not constrain the inputs. The strobe may arrive on any cycle, including mid-frame, and the mode may change at any time. The properties only assume that a frame starts at acceptance and lasts exactly the slot count of the mode latched then. To stay inside these conditions, the stimulus changes inputs only on falling edges. It covers strobes held high for many cycles, strobes landing mid-frame, and mode and pixel changes during a frame. The bench model decides acceptance from the same boundary rule, so no stimulus needs to stay aligned to frame boundaries.

// File: rtl/pxl_link_pkg.sv
package pxl_link_pkg;

    localparam int COLOR_W     = 8;
    localparam int NARROW_W    = 6;
    localparam int CTRL_W      = 3;
    localparam int SEQ_W       = 2;
    localparam int RSV_W       = 2;
    localparam int NARROW_BITS = 3 * NARROW_W + CTRL_W + 1 + SEQ_W;
    localparam int WIDE_BITS   = 3 * COLOR_W + CTRL_W + 1 + SEQ_W + RSV_W;

    typedef logic [COLOR_W-1:0]   chan_t;
    typedef logic [SEQ_W-1:0]     seq_t;
    typedef logic [WIDE_BITS-1:0] payload_t;

    typedef enum logic {
        LINK_NARROW = 1'b0,
        LINK_WIDE   = 1'b1
    } link_mode_e;

    typedef struct packed {
        chan_t r;
        chan_t g;
        chan_t b;
        logic  vs;
        logic  hs;
        logic  de;
    } pixel_t;

    function automatic logic [3*COLOR_W-1:0] full_colors(pixel_t px);
        return {px.r, px.g, px.b};
    endfunction

    function automatic logic [3*NARROW_W-1:0] top_colors(pixel_t px);
        return {px.r[COLOR_W-1 -: NARROW_W],
                px.g[COLOR_W-1 -: NARROW_W],
                px.b[COLOR_W-1 -: NARROW_W]};
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_bits(pixel_t px);
        return {px.vs, px.hs, px.de};
    endfunction

    function automatic int slots_for(link_mode_e m, int lanes);
        return (m == LINK_WIDE) ? WIDE_BITS / lanes : NARROW_BITS / lanes;
    endfunction

endpackage

// File: rtl/pxl_seq_counter.sv
module pxl_seq_counter
    import pxl_link_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output seq_t seq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            seq <= '0;
        end else if (adv) begin
            seq <= seq + seq_t'(1);
        end
    end
endmodule

// File: rtl/pxl_frame_builder.sv
module pxl_frame_builder
    import pxl_link_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int SLOT_W = 5
) (
    input  pixel_t            px,
    input  link_mode_e        mode,
    input  seq_t              seq,
    output payload_t          pay,
    output logic [SLOT_W-1:0] slots
);
    localparam int NARROW_SLOTS = NARROW_BITS / LANES;
    localparam int WIDE_SLOTS   = WIDE_BITS / LANES;

    logic [3*NARROW_W-1:0] col_n;
    logic [3*COLOR_W-1:0]  col_w;
    logic [CTRL_W-1:0]     ctl;
    logic                  pe_n;
    logic                  pe_w;
    logic [NARROW_BITS-1:0] msb_n;
    logic [WIDE_BITS-1:0]   msb_w;

    always_comb begin
        col_n = top_colors(px);
        col_w = full_colors(px);
        ctl   = ctrl_bits(px);
        pe_n  = ~^{col_n, ctl, seq};
        pe_w  = ~^{col_w, ctl, seq};
        msb_n = {col_n, ctl, pe_n, seq};
        msb_w = {col_w, ctl, pe_w, seq, {RSV_W{1'b0}}};
        slots = (mode == LINK_WIDE) ? SLOT_W'(WIDE_SLOTS) : SLOT_W'(NARROW_SLOTS);
    end

    // Transmit bit i sits at pay[i]; the first bit on the wire is bit 0.
    for (genvar i = 0; i < WIDE_BITS; i++) begin : g_order
        if (i < NARROW_BITS) begin : g_both
            assign pay[i] = (mode == LINK_WIDE) ? msb_w[WIDE_BITS-1-i]
                                                : msb_n[NARROW_BITS-1-i];
        end else begin : g_wide_only
            assign pay[i] = (mode == LINK_WIDE) ? msb_w[WIDE_BITS-1-i] : 1'b0;
        end
    end
endmodule

// File: rtl/pxl_lane_shifter.sv
module pxl_lane_shifter
    import pxl_link_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  payload_t          pay_in,
    input  logic [SLOT_W-1:0] slots_in,
    output payload_t          pay_q,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] frame_slots,
    output logic              busy,
    output logic              last,
    output logic [LANES-1:0]  lane_d
);
    assign last = busy && (slot == frame_slots - SLOT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_q       <= '0;
            slot        <= '0;
            frame_slots <= '0;
            busy        <= 1'b0;
        end else if (load) begin
            pay_q       <= pay_in;
            slot        <= '0;
            frame_slots <= slots_in;
            busy        <= 1'b1;
        end else if (busy) begin
            pay_q <= pay_q >> LANES;
            if (last) begin
                slot <= '0;
                busy <= 1'b0;
            end else begin
                slot <= slot + SLOT_W'(1);
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_d[l] = pay_q[l];
    end
endmodule

// File: rtl/pxl_link_serializer.sv
module pxl_link_serializer
    import pxl_link_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_stb,
    input  logic               wide_mode,
    input  logic [COLOR_W-1:0] pix_r,
    input  logic [COLOR_W-1:0] pix_g,
    input  logic [COLOR_W-1:0] pix_b,
    input  logic               pix_vs,
    input  logic               pix_hs,
    input  logic               pix_de,
    output logic [LANES-1:0]   lane_d,
    output logic               link_ck
);
    localparam int MAX_SLOTS = WIDE_BITS / LANES;
    localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);

    pixel_t            px;
    link_mode_e        mode;
    seq_t              seq;
    payload_t          pay_next;
    payload_t          pay_q;
    logic [SLOT_W-1:0] slots_next;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] frame_slots;
    logic              busy;
    logic              last;
    logic              accept;

    assign px     = '{r: pix_r, g: pix_g, b: pix_b, vs: pix_vs, hs: pix_hs, de: pix_de};
    assign mode   = link_mode_e'(wide_mode);
    assign accept = pix_stb && (!busy || last);
    assign link_ck = busy && !slot[0];

    pxl_seq_counter u_seq (
        .clk (clk),
        .rst (rst),
        .adv (accept),
        .seq (seq)
    );

    pxl_frame_builder #(.LANES(LANES), .SLOT_W(SLOT_W)) u_build (
        .px    (px),
        .mode  (mode),
        .seq   (seq),
        .pay   (pay_next),
        .slots (slots_next)
    );

    pxl_lane_shifter #(.LANES(LANES), .SLOT_W(SLOT_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .pay_in      (pay_next),
        .slots_in    (slots_next),
        .pay_q       (pay_q),
        .slot        (slot),
        .frame_slots (frame_slots),
        .busy        (busy),
        .last        (last),
        .lane_d      (lane_d)
    );
endmodule

// File: rtl/pxl_link_serializer_chk.sv
module pxl_link_serializer_chk
    import pxl_link_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int SLOT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              accept,
    input logic              wide_mode,
    input seq_t              seq,
    input payload_t          pay_q,
    input logic [SLOT_W-1:0] slot,
    input logic [SLOT_W-1:0] frame_slots,
    input logic              busy,
    input logic [LANES-1:0]  lane_d,
    input logic              link_ck
);
    localparam int NSL = NARROW_BITS / LANES;
    localparam int WSL = WIDE_BITS / LANES;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lane_d == '0 && !link_ck)) else $error("idle lanes active"); // R9

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        accept |=> seq == seq_t'($past(seq) + seq_t'(1))) else $error("seq step"); // R5

    AST_PARITY_ODD: assert property (@(posedge clk) disable iff (rst)
        accept |=> ($countones(pay_q) % 2) == 1) else $error("parity even"); // R4

    AST_MIDFRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && slot != frame_slots - SLOT_W'(1)) |=> (busy && slot == SLOT_W'($past(slot) + SLOT_W'(1))))
        else $error("frame disturbed"); // R7

    AST_NARROW_LEN: assert property (@(posedge clk) disable iff (rst)
        (accept && !wide_mode) |=> frame_slots == SLOT_W'(NSL)) else $error("narrow len"); // R2

    AST_WIDE_LEN: assert property (@(posedge clk) disable iff (rst)
        (accept && wide_mode) |=> frame_slots == SLOT_W'(WSL)) else $error("wide len"); // R3

    AST_CK_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (busy && slot != '0) |-> link_ck != $past(link_ck)) else $error("ck phase"); // R10
endmodule

bind pxl_link_serializer pxl_link_serializer_chk #(.LANES(LANES), .SLOT_W(SLOT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .wide_mode   (wide_mode),
    .seq         (seq),
    .pay_q       (pay_q),
    .slot        (slot),
    .frame_slots (frame_slots),
    .busy        (busy),
    .lane_d      (lane_d),
    .link_ck     (link_ck)
);

// File: tb/test_pxl_link_serializer.sv
module test_pxl_link_serializer;
    logic       clk = 1'b0;
    logic       rst;
    logic       pix_stb;
    logic       wide_mode;
    logic [7:0] pix_r, pix_g, pix_b;
    logic       pix_vs, pix_hs, pix_de;
    logic [1:0] lane_d;
    logic       link_ck;

    always #4 clk = ~clk;

    pxl_link_serializer i_pxl_link_serializer (
        .clk(clk), .rst(rst), .pix_stb(pix_stb), .wide_mode(wide_mode),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_vs(pix_vs), .pix_hs(pix_hs), .pix_de(pix_de),
        .lane_d(lane_d), .link_ck(link_ck)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string tag = "R1";

    // behavioural reference
    int m_bits[$];
    int m_slots = 0;
    int m_cur = 0;
    bit m_busy = 0;
    int m_seq = 0;
    int m_frames = 0;

    function automatic void push_chan(logic [7:0] c, int lo);
        for (int k = 7; k >= lo; k--) m_bits.push_back(int'(c[k]));
    endfunction

    function automatic void build_frame();
        int ones;
        int lo;
        m_bits.delete();
        lo = wide_mode ? 0 : 2;
        push_chan(pix_r, lo);
        push_chan(pix_g, lo);
        push_chan(pix_b, lo);
        m_bits.push_back(int'(pix_vs));
        m_bits.push_back(int'(pix_hs));
        m_bits.push_back(int'(pix_de));
        ones = 0;
        foreach (m_bits[i]) ones += m_bits[i];
        ones += (m_seq / 2) + (m_seq % 2);
        m_bits.push_back((ones % 2 == 0) ? 1 : 0);
        m_bits.push_back(m_seq / 2);
        m_bits.push_back(m_seq % 2);
        if (wide_mode) begin
            m_bits.push_back(0);
            m_bits.push_back(0);
        end
        m_slots = m_bits.size() / 2;
    endfunction

    function automatic void model_edge();
        if (rst) begin
            m_busy = 0; m_seq = 0; m_cur = 0;
        end else if (pix_stb && (!m_busy || m_cur == m_slots - 1)) begin
            build_frame();
            m_seq = (m_seq + 1) % 4;
            m_cur = 0;
            m_busy = 1;
            m_frames++;
        end else if (m_busy) begin
            m_cur++;
            if (m_cur == m_slots) m_busy = 0;
        end
    endfunction

    task automatic compare();
        logic [1:0] e_l;
        logic       e_ck;
        e_l  = m_busy ? {logic'(m_bits[2*m_cur+1]), logic'(m_bits[2*m_cur])} : 2'b00;
        e_ck = m_busy && (m_cur % 2 == 0);
        n_cmp++;
        if (lane_d !== e_l || link_ck !== e_ck) begin
            n_bad++;
            $display("FAIL %s: lane_d=%b link_ck=%b expected lane_d=%b link_ck=%b (slot %0d)",
                     tag, lane_d, link_ck, e_l, e_ck, m_cur);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic set_px(int s);
        pix_r  = 8'(s * 37 + 5);
        pix_g  = 8'(s * 91 + 200);
        pix_b  = 8'(s * 13 ^ 8'h5A);
        pix_vs = s[0];
        pix_hs = s[1];
        pix_de = s[2];
    endtask

    task automatic send(int s, logic wm, int gap);
        set_px(s);
        wide_mode = wm;
        pix_stb = 1'b1;
        cyc();
        pix_stb = 1'b0;
        for (int g = 0; g < gap; g++) cyc();
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pix_stb = 1'b0; wide_mode = 1'b0;
        set_px(0);
        // R1: reset state, strobe during reset has no effect
        tag = "R1";
        pix_stb = 1'b1;
        for (int i = 0; i < 3; i++) cyc();
        pix_stb = 1'b0;
        rst = 1'b0;
        tag = "R1 R9";
        for (int i = 0; i < 3; i++) cyc();

        // R2 R4 R5 R6 R10: narrow frames back to back, seq wraps
        tag = "R2 R4 R5 R6 R10";
        for (int f = 0; f < 6; f++) send(f + 1, 1'b0, 11);

        // R3 R4 R5: wide frames back to back
        tag = "R3 R4 R5 R6 R10";
        for (int f = 0; f < 5; f++) send(f + 20, 1'b1, 15);

        // R4: all zero and all one pixels in both modes
        tag = "R4";
        pix_r = 8'h00; pix_g = 8'h00; pix_b = 8'h00; pix_vs = 0; pix_hs = 0; pix_de = 0;
        wide_mode = 1'b1; pix_stb = 1'b1; cyc(); pix_stb = 1'b0;
        for (int i = 0; i < 15; i++) cyc();
        pix_r = 8'hFF; pix_g = 8'hFF; pix_b = 8'hFF; pix_vs = 1; pix_hs = 1; pix_de = 1;
        wide_mode = 1'b0; pix_stb = 1'b1; cyc(); pix_stb = 1'b0;
        for (int i = 0; i < 11; i++) cyc();

        // R9: idle gap after a frame
        tag = "R9";
        for (int i = 0; i < 6; i++) cyc();

        // R7: strobe held high with changing data, only boundaries take it
        tag = "R7";
        wide_mode = 1'b1;
        pix_stb = 1'b1;
        for (int i = 0; i < 45; i++) begin
            set_px(i + 50);
            wide_mode = (i > 30);
            cyc();
        end
        pix_stb = 1'b0;
        for (int i = 0; i < 17; i++) cyc();

        // R8: inputs and mode change during a frame
        tag = "R8";
        send(77, 1'b0, 0);
        for (int i = 0; i < 11; i++) begin
            set_px(i + 90);
            wide_mode = ~wide_mode;
            cyc();
        end
        send(78, 1'b1, 0);
        for (int i = 0; i < 15; i++) begin
            set_px(i + 120);
            wide_mode = ~wide_mode;
            cyc();
        end

        // R7: mid-frame strobes are dropped
        tag = "R7";
        send(5, 1'b1, 3);
        for (int i = 0; i < 4; i++) begin
            set_px(i + 200); pix_stb = 1'b1; cyc(); pix_stb = 1'b0; cyc();
        end
        for (int i = 0; i < 10; i++) cyc();

        // R1: reset mid-frame returns to quiet state and seq 0
        tag = "R1";
        send(9, 1'b1, 4);
        rst = 1'b1; cyc(); cyc(); rst = 1'b0;
        cyc();
        send(10, 1'b0, 14);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule